// File: doc/BRIEF.md
# System Bus Address Decoder

This block sits between a single bus master and the slaves of a system bus. In each address phase it looks at the 32-bit address and raises exactly one target select. The targets are boot flash, two on-chip SRAM banks, four APB cluster bridges and two standalone register slaves. An address that matches none of them goes to a built-in default responder, which ends the transfer with a two-cycle error so that the processor takes an abort. This applies to instruction fetches and data accesses alike, because the decoder ignores the access kind.

The 4 GB space is cut into eight 512 MB regions by the top three address bits:

| Address range | Target |
|---|---|
| `0x0000_0000` | boot alias |
| `0x4000_0000` | flash |
| `0x8000_0000` | SRAM |
| `0xE000_0000` | peripherals |

The other regions are unused. In the peripheral region the lower half holds APB clusters on 256 kB boundaries, and each cluster holds 4 kB peripheral slots. The upper half holds 1 MB slots for standalone slaves.

Decode stops at slot level. Any offset inside an assigned slot is accepted, and the slave resolves it itself.

After reset the flash is also visible at address zero, so that the exception vectors can be fetched from it. Software turns this alias off by writing a one to a sticky control bit that lives inside the decoder. Write transfers are passed to the selected target with an aligned address, and never raise an error because they are misaligned. In the data phase the decoder returns ready, response and read data from the target that won the previous accepted address phase.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: After reset, a transfer whose address lies in region 0 below the flash size (default 256 kB, so `0x0000_0000`–`0x0003_FFFF`) selects the flash (`hsel` bit 0). This holds for the vector addresses `0x00`–`0x1C`.
- R2: The remap bit reads back at bit 0 of address `0xF020_0000` and resets to 0.
  - A write with data bit 0 = 1 sets the bit. It then stays set until reset, and writes of 0 do not clear it.
  - While the bit is set, region 0 decodes to the default responder.
  - Accesses to this address never assert any `hsel` bit and complete without error.
- R3: Addresses from `0x4000_0000` up to the flash size always select the flash. Higher addresses in that region get an error.
- R4: SRAM bank 0 (`hsel` bit 1) covers `0x8000_0000`–`0x8000_7FFF`. Bank 1 (`hsel` bit 2) covers `0x8000_8000`–`0x8000_BFFF`. The rest of region 4 gets an error.
- R5: The unused regions starting at `0x2000_0000`, `0x6000_0000`, `0xA000_0000` and `0xC000_0000` always get an error.
- R6: APB cluster selection works as follows.
  - Cluster c (c = 0..3) occupies `0xE000_0000 + c*0x4_0000`, and its slot s sits at `+ s*0x1000`.
  - A populated slot selects `hsel` bit 3+c. The default populated slots are 0–7, 0–3, 0–1 and 0–4 for clusters 0 to 3.
  - An unpopulated slot, or a cluster index of 4 or more, gets an error.
- R7: Any byte offset inside an assigned peripheral or standalone slot selects that slot's target without error.
- R8: Standalone slave A (`hsel` bit 7) is the 1 MB slot at `0xF000_0000`, and slave B (`hsel` bit 8) is the slot at `0xF010_0000`. Every other slot in `0xF000_0000`–`0xFFFF_FFFF` except the remap slot gets an error.
- R9: An erroring transfer has a data phase of exactly two cycles:
  - the first with `hready`=0 and `hresp`=1;
  - the second with `hready`=1 and `hresp`=1.
  
  This holds for reads and writes.
- R10: While `htrans[1]`=0 (IDLE or BUSY), `hsel` is all zero. While `htrans[1]`=1, at most one `hsel` bit is set, and none is set exactly when the default responder or the remap bit is the target. Bit order: 0 flash, 1 SRAM0, 2 SRAM1, 3..6 clusters 0..3, 7 slave A, 8 slave B.
- R11: Writes are forwarded aligned:
  - a byte write (`hsize`=0) goes out as a halfword (`fwd_size`=1) with address bit 0 cleared;
  - a halfword write keeps its size with address bit 0 cleared;
  - a word write has address bits 1:0 cleared;
  - reads pass address and size through unchanged;
  - misalignment never causes an error.
- R12: With no data phase pending, `hready`=1 and `hresp`=0. In the data phase of an external target, `hready`, `hresp` and `hrdata` come from that target's slice of `t_hready`, `t_hresp` and `t_hrdata` (bits 32*i+31:32*i for target i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type; bit 1 marks NONSEQ/SEQ |
| hwrite | input | 1 | Write when high |
| hsize | input | 3 | Transfer size code |
| hwdata | input | 32 | Write data (data phase) |
| hsel | output | 9 | One-hot target select |
| fwd_addr | output | 32 | Address forwarded to targets |
| fwd_size | output | 3 | Size forwarded to targets |
| t_hready | input | 9 | Ready from each target |
| t_hresp | input | 9 | Error response from each target |
| t_hrdata | input | 288 | Read data from each target, 32 bits each |
| hready | output | 1 | Ready to the master |
| hresp | output | 1 | Error response to the master |
| hrdata | output | 32 | Read data to the master |

## Verification
A corrupted target index stored for the data phase shows up on `hready`, `hresp` or `hrdata` in the very next cycle: the wrong target's data word appears, or an error turns up where none is due. A remap bit that is set too early, cleared again or never set changes which select region 0 raises. This is visible in the first address phase that follows. A default responder stuck in the wrong phase shows either a missing wait cycle or a stalled bus within two cycles of the faulty transfer.

// File: rtl/sysbus_addr_decoder.sv
`timescale 1ns/1ps
module sysbus_addr_decoder #(
  parameter int FLASH_AW = 18,
  parameter int SRAM0_AW = 15,
  parameter int SRAM1_AW = 14,
  parameter logic [255:0] CLUSTER_SLOTS = {64'h1F, 64'h03, 64'h0F, 64'hFF}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  haddr,
  input  logic [1:0]   htrans,
  input  logic         hwrite,
  input  logic [2:0]   hsize,
  input  logic [31:0]  hwdata,
  output logic [8:0]   hsel,
  output logic [31:0]  fwd_addr,
  output logic [2:0]   fwd_size,
  input  logic [8:0]   t_hready,
  input  logic [8:0]   t_hresp,
  input  logic [287:0] t_hrdata,
  output logic         hready,
  output logic         hresp,
  output logic [31:0]  hrdata
);
  localparam int NEXT = 9;
  localparam int NALL = NEXT + 2;
  localparam logic [3:0] I_FLASH = 4'd0, I_SR0 = 4'd1, I_SR1 = 4'd2, I_APB0 = 4'd3;
  localparam logic [3:0] I_SLVA = 4'd7, I_SLVB = 4'd8, I_RMP = 4'd9, I_DEF = 4'd10;
  localparam logic [31:0] FLASH_LIM = 32'd1 << FLASH_AW;
  localparam logic [31:0] SR0_LIM = 32'd1 << SRAM0_AW;
  localparam logic [31:0] SR1_LIM = SR0_LIM + (32'd1 << SRAM1_AW);

  logic            natural_map;
  logic            d_act, d_wr;
  logic [3:0]      d_tgt;
  logic [1:0]      err_ph;
  logic [3:0]      tgt;
  logic [NALL-1:0] sel_all;
  logic [31:0]     off;
  logic            accept;
  logic            unused_wdata;

  assign off = {3'b000, haddr[28:0]};
  assign unused_wdata = ^hwdata[31:1];

  always_comb begin
    tgt = I_DEF;
    case (haddr[31:29])
      3'd0: if (!natural_map && off < FLASH_LIM) tgt = I_FLASH;
      3'd2: if (off < FLASH_LIM) tgt = I_FLASH;
      3'd4: begin
        if (off < SR0_LIM) tgt = I_SR0;
        else if (off < SR1_LIM) tgt = I_SR1;
      end
      3'd7: begin
        if (!haddr[28]) begin
          if (haddr[27:20] == 8'd0 && CLUSTER_SLOTS[{haddr[19:18], haddr[17:12]}])
            tgt = I_APB0 + {2'b00, haddr[19:18]};
        end else begin
          case (haddr[27:20])
            8'd0:    tgt = I_SLVA;
            8'd1:    tgt = I_SLVB;
            8'd2:    tgt = I_RMP;
            default: tgt = I_DEF;
          endcase
        end
      end
      default: tgt = I_DEF;
    endcase
  end

  assign sel_all  = htrans[1] ? (NALL'(1) << tgt) : '0;
  assign hsel     = sel_all[NEXT-1:0];
  assign accept   = hready && htrans[1];
  assign fwd_addr = !hwrite ? haddr :
                    (hsize[2:1] == 2'b00) ? {haddr[31:1], 1'b0} : {haddr[31:2], 2'b00};
  assign fwd_size = (hwrite && hsize == 3'd0) ? 3'd1 : hsize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      natural_map <= 1'b0;
      d_act  <= 1'b0;
      d_wr   <= 1'b0;
      d_tgt  <= I_DEF;
      err_ph <= 2'd0;
    end else begin
      if (d_act && d_tgt == I_RMP && d_wr && hwdata[0]) natural_map <= 1'b1;
      if (err_ph == 2'd1) err_ph <= 2'd2;
      else if (hready) begin
        d_act  <= accept;
        d_wr   <= hwrite;
        d_tgt  <= tgt;
        err_ph <= (accept && tgt == I_DEF) ? 2'd1 : 2'd0;
      end
    end
  end

  always_comb begin
    hready = 1'b1;
    hresp  = 1'b0;
    hrdata = '0;
    if (d_act) begin
      if (d_tgt < 4'(NEXT)) begin
        hready = t_hready[d_tgt];
        hresp  = t_hresp[d_tgt];
        hrdata = t_hrdata[d_tgt*32 +: 32];
      end else if (d_tgt == I_RMP) begin
        hrdata = {31'b0, natural_map};
      end else begin
        hresp  = 1'b1;
        hready = err_ph[1];
      end
    end
  end

  p_err_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && sel_all[I_DEF] |=> (!hready && hresp) ##1 (hready && hresp));
  p_unused_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (haddr[31:29] inside {3'd1, 3'd3, 3'd5, 3'd6}) |=> (!hready && hresp));
  p_remap_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_act && d_tgt == I_RMP && d_wr && hwdata[0] |=> natural_map);
  p_remap_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    natural_map |=> natural_map);
  p_idle_nosel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !htrans[1] |-> hsel == '0);
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hsel));
  p_wr_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    htrans[1] && hwrite |-> !fwd_addr[0] && fwd_size != 3'd0);
endmodule

// File: tb/sim_sysbus_addr_decoder.sv
`timescale 1ns/1ps
module sim_sysbus_addr_decoder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  haddr = '0;
  logic [1:0]   htrans = 2'b00;
  logic         hwrite = 1'b0;
  logic [2:0]   hsize = 3'd2;
  logic [31:0]  hwdata = '0;
  logic [8:0]   hsel;
  logic [31:0]  fwd_addr;
  logic [2:0]   fwd_size;
  logic [8:0]   t_hready = '1;
  logic [8:0]   t_hresp = '0;
  logic [287:0] t_hrdata;
  logic         hready, hresp;
  logic [31:0]  hrdata;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 9; i++) begin : g_resp
    assign t_hrdata[i*32 +: 32] = 32'hC0DE_0000 + i;
  end

  sysbus_addr_decoder u0 (.*);

  typedef struct packed {
    logic [8:0]  sel;
    logic        err;
    logic [31:0] fa;
    logic [2:0]  fs;
    logic        chk_rd;
    logic [31:0] rd;
  } item_t;

  item_t q[$];
  string qt[$];
  int n_chk = 0, n_fail = 0;
  logic nat_model = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor
  bit pend = 1'b0;
  int cyc = 0;
  item_t cur;
  string ctag;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        if (cur.err) begin
          if (cyc == 0) begin
            chk(!hready && hresp, {"R9 err cycle1 ", ctag}, {hready, hresp}, 2'b01);
            cyc = 1;
          end else begin
            chk(hready && hresp, {"R9 err cycle2 ", ctag}, {hready, hresp}, 2'b11);
            pend = 1'b0;
          end
        end else begin
          chk(hready && !hresp, {"R12 ok resp ", ctag}, {hready, hresp}, 2'b10);
          if (cur.chk_rd) chk(hrdata == cur.rd, {"R12 rdata ", ctag}, hrdata, cur.rd);
          pend = 1'b0;
        end
      end else if (htrans[1] && hready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected address phase", haddr, 0);
        end else begin
          cur = q.pop_front();
          ctag = qt.pop_front();
          chk(hsel == cur.sel, {"R10 select ", ctag}, hsel, cur.sel);
          chk(fwd_addr == cur.fa && fwd_size == cur.fs, {"R11 forward ", ctag},
              {fwd_size, fwd_addr}, {cur.fs, cur.fa});
          pend = 1'b1;
          cyc = 0;
        end
      end
    end
  end

  // driver: idx 0..8 external target, 9 remap bit, 10 error
  task automatic xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                      input logic [31:0] wd, input int idx, input string tag);
    item_t it;
    it.sel = (idx < 9) ? 9'(1 << idx) : 9'd0;
    it.err = (idx == 10);
    it.fa  = !w ? a : (sz < 3'd2) ? {a[31:1], 1'b0} : {a[31:2], 2'b00};
    it.fs  = (w && sz == 3'd0) ? 3'd1 : sz;
    it.chk_rd = !w && idx != 10;
    it.rd  = (idx < 9) ? 32'hC0DE_0000 + idx : {31'b0, nat_model};
    @(posedge clk);
    #1;
    haddr = a; hwrite = w; hsize = sz; htrans = 2'b10;
    q.push_back(it);
    qt.push_back(tag);
    @(posedge clk);
    #1;
    htrans = 2'b00; hwdata = wd;
    do @(negedge clk); while (!hready);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(hready && !hresp && hsel == 0, "R12 reset state", {hready, hresp, hsel}, {2'b10, 9'd0});

    xfer(32'h0000_0000, 0, 3'd2, 0, 0, "R1 alias vector 0x00");
    xfer(32'h0000_001C, 0, 3'd2, 0, 0, "R1 alias vector 0x1C");
    xfer(32'h4000_0000, 0, 3'd2, 0, 0, "R3 flash base");
    xfer(32'h4003_FFFC, 0, 3'd2, 0, 0, "R3 flash top");
    xfer(32'h4004_0000, 0, 3'd2, 0, 10, "R3 beyond flash");
    xfer(32'h8000_0000, 0, 3'd2, 0, 1, "R4 sram0 base");
    xfer(32'h8000_7FFC, 0, 3'd2, 0, 1, "R4 sram0 top");
    xfer(32'h8000_8000, 0, 3'd2, 0, 2, "R4 sram1 base");
    xfer(32'h8000_BFFC, 0, 3'd2, 0, 2, "R4 sram1 top");
    xfer(32'h8000_C000, 0, 3'd2, 0, 10, "R4 beyond banks");
    xfer(32'h2000_0000, 0, 3'd2, 0, 10, "R5 region 1");
    xfer(32'h6000_0100, 0, 3'd2, 0, 10, "R5 region 3");
    xfer(32'hA000_0000, 1, 3'd2, 32'h1, 10, "R5 region 5 write");
    xfer(32'hC000_0000, 0, 3'd2, 0, 10, "R5 region 6");
    xfer(32'hE000_0000, 0, 3'd2, 0, 3, "R6 cluster0 slot0");
    xfer(32'hE000_7000, 0, 3'd2, 0, 3, "R6 cluster0 slot7");
    xfer(32'hE000_8000, 0, 3'd2, 0, 10, "R6 cluster0 slot8 unassigned");
    xfer(32'hE004_3000, 0, 3'd2, 0, 4, "R6 cluster1 slot3");
    xfer(32'hE004_4000, 0, 3'd2, 0, 10, "R6 cluster1 slot4 unassigned");
    xfer(32'hE008_1000, 0, 3'd2, 0, 5, "R6 cluster2 slot1");
    xfer(32'hE00C_4000, 0, 3'd2, 0, 6, "R6 cluster3 slot4");
    xfer(32'hE00C_5000, 0, 3'd2, 0, 10, "R6 cluster3 slot5 unassigned");
    xfer(32'hE010_0000, 0, 3'd2, 0, 10, "R6 cluster4 absent");
    xfer(32'hE000_2FFC, 0, 3'd2, 0, 3, "R7 odd offset cluster0");
    xfer(32'hE00C_4ABC, 0, 3'd2, 0, 6, "R7 odd offset cluster3");
    xfer(32'hF00F_FFF0, 0, 3'd2, 0, 7, "R7 top of slave A slot");
    xfer(32'hF000_0000, 0, 3'd2, 0, 7, "R8 slave A");
    xfer(32'hF010_0040, 0, 3'd2, 0, 8, "R8 slave B");
    xfer(32'hF030_0000, 0, 3'd2, 0, 10, "R8 unassigned slot");
    xfer(32'h8000_0003, 1, 3'd0, 32'h5, 1, "R11 byte write");
    xfer(32'h8000_0005, 1, 3'd1, 32'h5, 1, "R11 halfword write");
    xfer(32'h8000_0006, 1, 3'd2, 32'h5, 1, "R11 word write");
    xfer(32'h8000_0003, 0, 3'd0, 0, 1, "R11 byte read unchanged");

    // R10: BUSY and IDLE raise no select
    @(posedge clk);
    #1 haddr = 32'h4000_0000; htrans = 2'b01;
    @(negedge clk);
    chk(hsel == 0, "R10 busy no select", hsel, 0);
    @(posedge clk);
    #1 htrans = 2'b00;
    @(negedge clk);
    chk(hsel == 0, "R10 idle no select", hsel, 0);

    xfer(32'hF020_0000, 0, 3'd2, 0, 9, "R2 remap reads 0");
    xfer(32'hF020_0000, 1, 3'd2, 32'h0, 9, "R2 write 0 ignored");
    xfer(32'h0000_0000, 0, 3'd2, 0, 0, "R2 alias kept after write 0");
    xfer(32'hF020_0000, 1, 3'd2, 32'h1, 9, "R2 write 1");
    nat_model = 1'b1;
    xfer(32'hF020_0000, 0, 3'd2, 0, 9, "R2 remap reads 1");
    xfer(32'h0000_0000, 0, 3'd2, 0, 10, "R2 region0 errors after remap");
    xfer(32'h0000_0004, 1, 3'd2, 32'h0, 10, "R2 region0 write errors");
    xfer(32'hF020_0000, 1, 3'd2, 32'h0, 9, "R2 write 0 after set");
    xfer(32'hF020_0000, 0, 3'd2, 0, 9, "R2 bit sticky");
    xfer(32'h4000_0010, 0, 3'd2, 0, 0, "R3 flash after remap");

    repeat (3) @(negedge clk);
    chk(q.size() == 0 && !pend, "R10 all phases observed", q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule